// File: doc/BRIEF.md
# Dual-Channel DAC Serial Write Controller

This block is a serial master that loads an external two-channel 12-bit digital-to-analogue converter. A request carries a channel select, a gain select, an output-enable control and a data value. A request can also ask for a paired update, which carries a value for each channel. Requests are taken over a valid/ready handshake. For each converter write the block builds a 16-bit command word and shifts it out on a chip select, a serial clock and a serial data line in SPI mode 0 (clock idles low, the slave samples on the rising edge).

Two update styles are supported. A single write holds the latch-control line low for the whole frame, so the addressed output changes when chip select rises. A paired write keeps the latch-control line high while it writes channel A and then channel B. One serial-clock period after the second frame ends, it drives the line low for one serial-clock period, so both outputs change at the same moment.

Top module: `dac_spi_writer`

## Requirements
- R1: After reset, `spi_cs_n` and `dac_ldac_n` are 1, `spi_sck` is 0 and `req_ready` is 1.
- R2: Each frame carries exactly 16 bits, most significant first, with `spi_cs_n` low. Bit 15 selects the channel (1 = B, 0 = A). Bit 14 is driven 0. Bit 13 is the gain (1 = unity, 0 = double). Bit 12 is the output enable (1 = active, 0 = shut down). Bits 11..0 are the data.
- R3: `spi_sck` is 0 whenever `spi_cs_n` is 1. `spi_sdi` does not change while `spi_sck` is high.
- R4: A single write (`req_pair` = 0) goes to the channel named by `req_chan`. `dac_ldac_n` is 0 when `spi_cs_n` falls and when it rises for that frame, and is 1 again once `req_ready` returns.
- R5: A paired write (`req_pair` = 1) sends two frames: first channel A with `req_data`, then channel B with `req_data_b`. `req_chan` is ignored, and `dac_ldac_n` stays 1 across both frames.
- R6: After a paired write, `dac_ldac_n` falls exactly 2*HALF_DIV clocks after `spi_cs_n` rises at the end of the second frame, and stays low for exactly 2*HALF_DIV clocks.
- R7: Between consecutive frames `spi_cs_n` stays high for at least 2*HALF_DIV clocks. Between the two frames of a paired write it stays high for exactly that long.
- R8: `req_ready` falls the cycle after a request is accepted and stays low until the transaction ends. Request inputs changed during that time do not affect the frames sent.
- R9: The serial clock period within a frame is 2*HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid is also high |
| req_pair | input | 1 | 1 = paired A/B update, 0 = single write |
| req_chan | input | 1 | Channel for a single write (1 = B) |
| req_gain_1x | input | 1 | 1 = unity gain, 0 = double gain |
| req_active | input | 1 | 1 = output enabled, 0 = shut down |
| req_data | input | 12 | Data for a single write, or channel A data |
| req_data_b | input | 12 | Channel B data in a paired write |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_sdi | output | 1 | Serial data to the converter |
| dac_ldac_n | output | 1 | Active-low output latch control |

## Verification
A wrong shift count or a corrupted shift register shows up on the serial line within the frame in which it happens. It appears as a frame length other than 16 rising clock edges, or as a decoded word that differs from the one expected. A sequencer that takes the wrong branch shows on the latch line within one or two serial-clock periods of chip select rising. Examples are a missing second frame, a latch pulse after a single write, or a low level during a paired write. Timing-counter errors change the measured serial-clock period, the chip-select gap or the latch pulse width. These are counted in system clocks, so an error of a single clock is caught.

// File: rtl/dac_spi_writer.sv
module dac_spi_writer #(
  parameter int HALF_DIV = 2,
  parameter int DATA_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_pair,
  input  logic              req_chan,
  input  logic              req_gain_1x,
  input  logic              req_active,
  input  logic [DATA_W-1:0] req_data,
  input  logic [DATA_W-1:0] req_data_b,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_sdi,
  output logic              dac_ldac_n
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam int CNT_W   = $clog2(2 * HALF_DIV) + 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] PER_LAST  = CNT_W'(2 * HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_LATCH} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic               phase;
  logic [BIT_W-1:0]   bitcnt;
  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] word_b;
  logic               pair_q;
  logic               second_q;
  logic               ldac_q;

  function automatic logic [FRAME_W-1:0] pack(input logic ch, input logic g,
                                              input logic a, input logic [DATA_W-1:0] d);
    return {ch, 1'b0, g, a, d};
  endfunction

  wire half_done = (cnt == HALF_LAST);
  wire per_done  = (cnt == PER_LAST);

  assign req_ready  = (state == S_IDLE);
  assign spi_cs_n   = (state != S_SHIFT);
  assign spi_sck    = (state == S_SHIFT) & phase;
  assign spi_sdi    = (state == S_SHIFT) & shreg[FRAME_W-1];
  assign dac_ldac_n = ldac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      phase    <= 1'b0;
      bitcnt   <= '0;
      shreg    <= '0;
      word_b   <= '0;
      pair_q   <= 1'b0;
      second_q <= 1'b0;
      ldac_q   <= 1'b1;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          pair_q   <= req_pair;
          second_q <= 1'b0;
          shreg    <= pack(req_pair ? 1'b0 : req_chan, req_gain_1x, req_active, req_data);
          word_b   <= pack(1'b1, req_gain_1x, req_active, req_data_b);
          ldac_q   <= req_pair;
          cnt      <= '0;
          phase    <= 1'b0;
          bitcnt   <= '0;
          state    <= S_SHIFT;
        end
        S_SHIFT: if (half_done) begin
          cnt <= '0;
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (bitcnt == BIT_LAST) begin
              state <= S_GAP;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              shreg  <= shreg << 1;
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_GAP: if (per_done) begin
          cnt <= '0;
          if (pair_q && !second_q) begin
            second_q <= 1'b1;
            shreg    <= word_b;
            bitcnt   <= '0;
            phase    <= 1'b0;
            state    <= S_SHIFT;
          end else if (pair_q) begin
            ldac_q <= 1'b0;
            state  <= S_LATCH;
          end else begin
            ldac_q <= 1'b1;
            state  <= S_IDLE;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_LATCH: if (per_done) begin
          cnt    <= '0;
          ldac_q <= 1'b1;
          state  <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_spi_writer_chk.sv
module dac_spi_writer_chk #(
  parameter int HALF_DIV = 2,
  parameter int FRAME_W  = 16
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_pair,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_sdi,
  input logic dac_ldac_n
);
  logic        pair_seen;
  logic        sck_d;
  logic [7:0]  bit_cnt;
  logic [15:0] ldac_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_seen <= 1'b0;
      sck_d     <= 1'b0;
      bit_cnt   <= '0;
      ldac_run  <= '0;
    end else begin
      if (req_valid && req_ready) pair_seen <= req_pair;
      sck_d <= spi_sck;
      if (spi_cs_n) bit_cnt <= '0;
      else if (spi_sck && !sck_d) bit_cnt <= bit_cnt + 1'b1;
      if (!dac_ldac_n && pair_seen && spi_cs_n) ldac_run <= ldac_run + 1'b1;
      else ldac_run <= '0;
    end
  end

  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  p_sdi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_sdi));
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_ldac_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && !pair_seen) |-> !dac_ldac_n);
  p_ldac_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && pair_seen) |-> dac_ldac_n);
  p_ldac_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ldac_run <= 16'(2 * HALF_DIV));
  p_frame_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (bit_cnt == 8'(FRAME_W)));
endmodule

bind dac_spi_writer dac_spi_writer_chk #(.HALF_DIV(HALF_DIV), .FRAME_W(DATA_W + 4)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_pair(req_pair), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_sdi(spi_sdi),
  .dac_ldac_n(dac_ldac_n));

// File: tb/dac_spi_writer_tb.sv
`timescale 1ns/1ps
module dac_spi_writer_tb;
  localparam int H = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_pair = 1'b0, req_chan = 1'b0, req_gain_1x = 1'b0, req_active = 1'b0;
  logic [11:0] req_data = '0, req_data_b = '0;
  logic req_ready, spi_cs_n, spi_sck, spi_sdi, dac_ldac_n;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dac_spi_writer #(.HALF_DIV(H), .DATA_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pair(req_pair), .req_chan(req_chan), .req_gain_1x(req_gain_1x),
    .req_active(req_active), .req_data(req_data), .req_data_b(req_data_b),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_sdi(spi_sdi), .dac_ldac_n(dac_ldac_n));

  // frame monitor, sampled on the falling clock edge
  logic sck_p = 0, cs_p = 1, ldac_p = 1, sdi_p = 0;
  logic [15:0] shift_in, fw[8];
  int nbits, frames, fb[8];
  logic lf[8], lr[8];
  int per_cnt, per_min, per_max, cs_high, gap_last, gap_min, since, ldac_delay, ldac_low, ldac_width;
  int sck_viol, sdi_viol;

  task automatic clear_log();
    frames = 0; per_min = 1000; per_max = 0; gap_min = 1000; gap_last = 0;
    ldac_delay = -1; ldac_width = -1; sck_viol = 0; sdi_viol = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_cs_n && spi_sck) sck_viol++;
      if (sck_p && spi_sck && spi_sdi != sdi_p) sdi_viol++;
      if (cs_p && !spi_cs_n) begin
        shift_in = '0; nbits = 0; per_cnt = 0;
        if (frames < 8) lf[frames] = dac_ldac_n;
        if (frames > 0) begin gap_last = cs_high; if (cs_high < gap_min) gap_min = cs_high; end
      end
      if (!spi_cs_n) begin
        per_cnt++;
        if (!sck_p && spi_sck) begin
          if (nbits > 0) begin
            if (per_cnt < per_min) per_min = per_cnt;
            if (per_cnt > per_max) per_max = per_cnt;
          end
          per_cnt = 0;
          shift_in = {shift_in[14:0], spi_sdi};
          nbits++;
        end
      end
      if (!cs_p && spi_cs_n) begin
        if (frames < 8) begin fw[frames] = shift_in; fb[frames] = nbits; lr[frames] = dac_ldac_n; end
        frames++; since = 0; cs_high = 1;
      end else begin
        since++;
        if (spi_cs_n) cs_high++;
      end
      if (ldac_p && !dac_ldac_n) begin ldac_delay = since; ldac_low = 1; end
      else if (!dac_ldac_n) ldac_low++;
      if (!ldac_p && dac_ldac_n) ldac_width = ldac_low;
    end
    sck_p = spi_sck; cs_p = spi_cs_n; ldac_p = dac_ldac_n; sdi_p = spi_sdi;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic pair, input logic ch, input logic g, input logic a,
                      input logic [11:0] da, input logic [11:0] db);
    @(negedge clk);
    req_pair = pair; req_chan = ch; req_gain_1x = g; req_active = a;
    req_data = da; req_data_b = db; req_valid = 1'b1;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    #1 req_valid = 1'b0;
    req_pair = ~pair; req_chan = ~ch; req_gain_1x = ~g; req_active = ~a;
    req_data = ~da; req_data_b = ~db;
    @(negedge clk);
    chk(!req_ready, "R8 ready low after accept", req_ready, 0);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    chk(spi_cs_n == 1, "R1 cs_n", spi_cs_n, 1);
    chk(spi_sck == 0, "R1 sck", spi_sck, 0);
    chk(dac_ldac_n == 1, "R1 ldac_n", dac_ldac_n, 1);
  endtask

  task automatic t_single(input logic ch, input logic g, input logic a, input logic [11:0] d);
    logic [15:0] exp;
    exp = {ch, 1'b0, g, a, d};
    clear_log();
    send(1'b0, ch, g, a, d, ~d);
    chk(frames == 1, "R4 one frame", frames, 1);
    chk(fb[0] == 16, "R2 bit count", fb[0], 16);
    chk(fw[0] == exp, "R2/R8 word", fw[0], exp);
    chk(lf[0] == 0 && lr[0] == 0, "R4 ldac low over frame", {lf[0], lr[0]}, 0);
    chk(dac_ldac_n == 1, "R4 ldac released", dac_ldac_n, 1);
    chk(per_min == 2*H && per_max == 2*H, "R9 sck period", per_max, 2*H);
    chk(sck_viol == 0 && sdi_viol == 0, "R3 mode 0 rules", sck_viol + sdi_viol, 0);
  endtask

  task automatic t_back2back();
    clear_log();
    send(1'b0, 1'b0, 1'b1, 1'b1, 12'h001, 12'h0);
    send(1'b0, 1'b1, 1'b1, 1'b0, 12'h800, 12'h0);
    chk(frames == 2, "R7 two frames", frames, 2);
    chk(gap_min >= 2*H, "R7 gap between singles", gap_min, 2*H);
    chk(fw[1] == 16'hA800, "R2 second word", fw[1], 16'hA800);
  endtask

  task automatic t_pair(input logic ch, input logic g, input logic a,
                        input logic [11:0] da, input logic [11:0] db);
    logic [15:0] ea, eb;
    ea = {1'b0, 1'b0, g, a, da};
    eb = {1'b1, 1'b0, g, a, db};
    clear_log();
    send(1'b1, ch, g, a, da, db);
    repeat (2) @(negedge clk);
    chk(frames == 2, "R5 two frames", frames, 2);
    chk(fw[0] == ea, "R5 channel A word", fw[0], ea);
    chk(fw[1] == eb, "R5 channel B word", fw[1], eb);
    chk(fb[0] == 16 && fb[1] == 16, "R2 pair bit counts", fb[1], 16);
    chk(lf[0] && lr[0] && lf[1] && lr[1], "R5 ldac high over frames", {lf[0], lr[0], lf[1], lr[1]}, 4'hF);
    chk(gap_last == 2*H, "R7 gap inside pair", gap_last, 2*H);
    chk(ldac_delay == 2*H, "R6 ldac delay", ldac_delay, 2*H);
    chk(ldac_width == 2*H, "R6 ldac width", ldac_width, 2*H);
    chk(dac_ldac_n == 1, "R6 ldac back high", dac_ldac_n, 1);
    chk(sck_viol == 0 && sdi_viol == 0, "R3 mode 0 rules pair", sck_viol + sdi_viol, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single(1'b0, 1'b1, 1'b1, 12'hA5C);
    t_single(1'b1, 1'b0, 1'b0, 12'hFFF);
    t_single(1'b1, 1'b1, 1'b1, 12'h000);
    t_back2back();
    t_pair(1'b1, 1'b1, 1'b1, 12'h123, 12'hEDC);
    t_pair(1'b0, 1'b0, 1'b1, 12'h000, 12'hFFF);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule